// File: doc/BRIEF.md
# Iterative Quotient Estimator (128-bit by 64-bit)

This unit produces a fast 64-bit estimate of a 128-bit dividend divided by a normalized 64-bit divisor, the kind of step used when dividing floating-point significands. The caller presents the dividend as a high and a low word together with the divisor, pulses `start`, and collects the estimate when `done` pulses. The estimate is never below the exact truncated quotient and never more than two above it. A dividend whose quotient does not fit in 64 bits yields all ones.

The quotient is assembled as two 32-bit halves. The upper half comes from dividing the dividend's high word by the divisor's top 32 bits. The unit then forms the partial remainder as the full dividend minus the 128-bit product of the divisor and that upper guess. While that remainder is negative, it steps the guess down and adds the divisor back, shifted up 32 places. The lower half comes from dividing the middle 64 bits of the corrected remainder by the same 32-bit divisor slice. Both narrow divides share one radix-2 restoring divider that yields one quotient bit per cycle. Producing an exact remainder and making the final quotient correction are left to the caller.

Top module: `div_estimate_128`

## Requirements
- R1: After reset, `busy`, `done` and `quotient` are all zero.
- R2: When `divisor` is less than or equal to `num_hi`, the result is 0xFFFFFFFFFFFFFFFF. `done` rises one cycle after the `start` cycle.
- R3: The upper 32 result bits begin as `num_hi` divided by `divisor[63:32]`. They are forced to 0xFFFFFFFF when `divisor[63:32]` shifted up 32 places is less than or equal to `num_hi`.
- R4: The partial remainder is {num_hi,num_lo} minus divisor times the upper guess shifted up 32 places. While bit 127 of the remainder is set, the upper guess is lowered by one and divisor shifted up 32 places is added to the remainder.
- R5: The lower 32 result bits are remainder bits [95:32] divided by `divisor[63:32]`. They saturate to 0xFFFFFFFF when `divisor[63:32]` shifted up 32 places is less than or equal to those bits.
- R6: With `divisor[63]` set and `num_hi` below `divisor`, the result lies between the exact truncated quotient q and q+2, both included.
- R7: `done` is high for exactly one cycle, and only while `busy` is high. `busy` rises in the cycle after an accepted `start` and falls in the cycle after `done`.
- R8: A `start` that arrives while `busy` is high is ignored, and so are the operand values presented with it.
- R9: `quotient` changes only in the cycle in which `done` is high. It holds its value through later operand changes until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only when not busy |
| num_hi | input | 64 | Dividend, upper 64 bits |
| num_lo | input | 64 | Dividend, lower 64 bits |
| divisor | input | 64 | Divisor; bit 63 must be set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a valid `quotient` |
| quotient | output | 64 | Quotient estimate |

## Verification
The bench aims at the two saturation thresholds. The first is a high word equal to the divisor, where an off-by-one comparison would perform a real divide with a quotient too wide to represent. The second is a high word that reaches the divisor's top slice but stays below the full divisor, which forces the upper half to all ones and drives the remainder negative. A design with a broken add-back step would then return a value far outside the q..q+2 window, or stall in the correction state. Operands whose remainder middle bits cross the lower-half threshold check that the second saturation follows the same rule. A second `start` with different operands in mid-operation exposes a design that relatches its inputs.

// File: rtl/qest_pkg.sv
package qest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVH,
        ST_MUL,
        ST_FIX,
        ST_DIVL,
        ST_FIN
    } qest_state_e;

    // True when a half-quotient would not fit: slice shifted up <= numerator
    function automatic logic half_overflow(input logic [63:0] slice_up,
                                           input logic [63:0] numer);
        return slice_up <= numer;
    endfunction

endpackage

// File: rtl/qest_restoring_div.sv
module qest_restoring_div #(
    parameter int HW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2*HW-1:0] num,
    input  logic [HW-1:0]   den,
    output logic [HW-1:0]   quo,
    output logic            done
);
    localparam int CW = $clog2(HW + 1);

    logic [HW-1:0] rem_q;
    logic [HW-1:0] low_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [HW:0]   trial;
    logic [HW:0]   diff;
    logic          fits;

    always_comb begin
        trial = {rem_q, low_q[HW-1]};
        fits  = trial >= {1'b0, den};
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            low_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= num[2*HW-1:HW];
                low_q <= num[HW-1:0];
                cnt_q <= CW'(HW);
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[HW-1:0] : trial[HW-1:0];
                low_q <= {low_q[HW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) done_q <= 1'b1;
            end
        end
    end

    assign quo  = low_q;
    assign done = done_q;
endmodule

// File: rtl/qest_rem_unit.sv
module qest_rem_unit #(
    parameter int W = 64
) (
    input  logic [W-1:0]   num_hi,
    input  logic [W-1:0]   num_lo,
    input  logic [W-1:0]   divisor,
    input  logic [W/2-1:0] q_upper,
    input  logic [2*W-1:0] rem_in,
    output logic [2*W-1:0] rem_init,
    output logic [2*W-1:0] rem_added,
    output logic [W-1:0]   rem_mid
);
    localparam int H = W / 2;

    logic [W+H-1:0] prod;

    always_comb begin
        prod      = (W+H)'(divisor) * (W+H)'(q_upper);
        rem_init  = {num_hi, num_lo} - ((2*W)'(prod) << H);
        rem_added = rem_in + ((2*W)'(divisor) << H);
        rem_mid   = rem_in[W+H-1:H];
    end
endmodule

// File: rtl/div_estimate_128.sv
module div_estimate_128 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    import qest_pkg::*;

    localparam int H = W / 2;

    qest_state_e    state_q;
    logic [W-1:0]   hi_q, lo_q, d_q;
    logic [H-1:0]   qup_q;
    logic [W-1:0]   quo_q;
    logic [2*W-1:0] rem_q;

    logic [2*W-1:0] rem_init, rem_added;
    logic [W-1:0]   rem_mid;
    logic [W-1:0]   in_slice_up, held_slice_up;
    logic           accept, whole_sat, upper_sat, lower_sat, rem_neg;
    logic           div_start, div_done;
    logic [2*H-1:0] div_num;
    logic [H-1:0]   div_den, div_quo;

    always_comb begin
        in_slice_up   = {divisor[W-1:H], {H{1'b0}}};
        held_slice_up = {d_q[W-1:H], {H{1'b0}}};
        accept        = (state_q == ST_IDLE) && start;
        whole_sat     = divisor <= num_hi;
        upper_sat     = half_overflow(in_slice_up, num_hi);
        lower_sat     = half_overflow(held_slice_up, rem_mid);
        rem_neg       = rem_q[2*W-1];
        div_start     = (accept && !whole_sat && !upper_sat) ||
                        (state_q == ST_FIX && !rem_neg && !lower_sat);
        div_num       = (state_q == ST_IDLE) ? num_hi : rem_mid;
        div_den       = (state_q == ST_IDLE) ? divisor[W-1:H] : d_q[W-1:H];
    end

    qest_restoring_div #(.HW(H)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .done  (div_done)
    );

    qest_rem_unit #(.W(W)) u_rem (
        .num_hi    (hi_q),
        .num_lo    (lo_q),
        .divisor   (d_q),
        .q_upper   (qup_q),
        .rem_in    (rem_q),
        .rem_init  (rem_init),
        .rem_added (rem_added),
        .rem_mid   (rem_mid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hi_q    <= '0;
            lo_q    <= '0;
            d_q     <= '0;
            qup_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    hi_q <= num_hi;
                    lo_q <= num_lo;
                    d_q  <= divisor;
                    if (whole_sat) begin
                        quo_q   <= '1;
                        state_q <= ST_FIN;
                    end else if (upper_sat) begin
                        qup_q   <= '1;
                        state_q <= ST_MUL;
                    end else begin
                        state_q <= ST_DIVH;
                    end
                end
                ST_DIVH: if (div_done) begin
                    qup_q   <= div_quo;
                    state_q <= ST_MUL;
                end
                ST_MUL: begin
                    rem_q   <= rem_init;
                    state_q <= ST_FIX;
                end
                ST_FIX: begin
                    if (rem_neg) begin
                        qup_q <= qup_q - 1'b1;
                        rem_q <= rem_added;
                    end else if (lower_sat) begin
                        quo_q   <= {qup_q, {H{1'b1}}};
                        state_q <= ST_FIN;
                    end else begin
                        state_q <= ST_DIVL;
                    end
                end
                ST_DIVL: if (div_done) begin
                    quo_q   <= {qup_q, div_quo};
                    state_q <= ST_FIN;
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = state_q != ST_IDLE;
    assign done     = state_q == ST_FIN;
    assign quotient = quo_q;
endmodule

// File: rtl/qest_checker.sv
module qest_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] num_hi,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient
);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_launch_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_fast_saturate_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (divisor <= num_hi)) |=> (done && quotient == {W{1'b1}}));

    assert_hold_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |-> $stable(quotient));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |=> (done || $stable(quotient)));
endmodule

bind div_estimate_128 qest_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .num_hi   (num_hi),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .quotient (quotient)
);

// File: tb/div_estimate_128_bench.sv
module div_estimate_128_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] num_hi = '0, num_lo = '0, divisor = '0;
    logic        busy, done;
    logic [63:0] quotient;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    div_estimate_128 u_div_estimate_128 (
        .clk(clk), .rst(rst), .start(start), .num_hi(num_hi), .num_lo(num_lo),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient)
    );

    // {expect_saturate, hi, lo, divisor}
    localparam logic [192:0] VEC [10] = '{
        {1'b0, 64'h0000000000000000, 64'h0000000000000000, 64'h8000000000000000},
        {1'b0, 64'h0000000000000001, 64'h0000000000000000, 64'h8000000000000000},
        {1'b0, 64'hFFFFFFFFFFFFFFFE, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF},
        {1'b1, 64'h8000000000000005, 64'h0000000000000000, 64'h8000000000000005},
        {1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h1234000000000000, 64'h8000000000000000},
        {1'b0, 64'h7FFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000},
        {1'b0, 64'h8000000000000000, 64'h0000000000000000, 64'h8000000000000001},
        {1'b0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h80000000FFFFFFFF},
        {1'b0, 64'h123456789ABCDEF0, 64'h0FEDCBA987654321, 64'hF0E1D2C3B4A59687},
        {1'b0, 64'h80000000FFFFFFFF, 64'hAAAA5555AAAA5555, 64'h8000000100000000}
    };

    function automatic logic [63:0] model(input logic [63:0] hi, input logic [63:0] lo,
                                          input logic [63:0] d);
        logic [63:0]  z, mid, d0;
        logic [127:0] rem;
        if (d <= hi) return '1;
        d0 = {32'h0, d[63:32]};
        if ({d[63:32], 32'h0} <= hi) z = 64'hFFFFFFFF00000000;
        else z = (hi / d0) << 32;
        rem = {hi, lo} - 128'(d) * 128'(z);
        while (rem[127]) begin
            z   = z - 64'h0000000100000000;
            rem = rem + (128'(d) << 32);
        end
        mid = rem[95:32];
        if ({d[63:32], 32'h0} <= mid) z = z | 64'h00000000FFFFFFFF;
        else z = z | (mid / d0);
        return z;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d,
                          output logic [63:0] est, output int lat);
        @(negedge clk);
        num_hi = hi; num_lo = lo; divisor = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        est = quotient;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0]  est, exp, held;
        logic [127:0] q;
        int lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1", {62'h0, busy, done}, 64'h0);
        check(quotient == '0, "R1", quotient, 64'h0);

        // Table walk: R2, R3, R4, R5, R6, R7
        for (int i = 0; i < 10; i++) begin
            logic [63:0] h, l, d;
            h = VEC[i][191:128]; l = VEC[i][127:64]; d = VEC[i][63:0];
            run_op(h, l, d, est, lat);
            exp = model(h, l, d);
            check(done && busy, "R7", {62'h0, done, busy}, 64'h3);
            check(est == exp, "R3 R4 R5", est, exp);
            if (VEC[i][192]) begin
                check(est == '1, "R2", est, 64'hFFFFFFFFFFFFFFFF);
                check(lat == 0, "R2", 64'(lat), 64'h0);
            end else begin
                q = {h, l} / 128'(d);
                check(128'(est) >= q && 128'(est) <= q + 128'd2, "R6", est, q[63:0]);
            end
            @(negedge clk);
            check(!done && !busy, "R7", {62'h0, done, busy}, 64'h0);
        end

        // R8: start while busy is ignored
        @(negedge clk);
        num_hi = VEC[8][191:128]; num_lo = VEC[8][127:64]; divisor = VEC[8][63:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        num_hi = 64'h0; num_lo = 64'h5; divisor = 64'h8000000000000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin @(negedge clk); lat++; end
        exp = model(VEC[8][191:128], VEC[8][127:64], VEC[8][63:0]);
        check(quotient == exp, "R8", quotient, exp);
        @(negedge clk);
        check(!busy, "R8", {63'h0, busy}, 64'h0);

        // R9: result holds without a new start
        held = quotient;
        num_hi = 64'hFFFFFFFFFFFFFFFF; divisor = 64'h8000000000000000;
        repeat (6) @(negedge clk);
        check(quotient == held, "R9", quotient, held);

        // R1: reset mid-operation clears state
        run_op(64'h1, 64'h0, 64'h8000000000000000, est, lat);
        @(negedge clk);
        num_hi = 64'h0; num_lo = 64'h0; divisor = 64'h8000000000000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && quotient == '0, "R1", quotient, 64'h0);

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule